// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the single reservation of one hart and judges each store-conditional against it. The hart presents one retired atomic event per cycle (kind, byte address, access size, acquire and release bits). A second input carries store addresses that other harts commit to memory. Every result comes out one clock after its event. The results are: whether the store path should perform a write, the value to write back to the destination register of a store-conditional, a flag marking that register as a dependency source, the acquire and release ordering flags, the load/store nature of the operation, and a misalignment exception.

The reservation covers one naturally aligned granule of `GRAN_BYTES` bytes. A small two-state machine holds it. In `RS_IDLE` no reservation exists. In `RS_HELD` a granule is reserved. The transitions are:
- `LR_TAKE` (IDLE to HELD): an aligned load-reserved opens a reservation.
- `LR_REPLACE` (HELD to HELD): a new aligned load-reserved moves the reservation to its own granule.
- `SC_CLOSE` (HELD to IDLE): any aligned store-conditional ends the reservation.
- `SNOOP_BREAK` (HELD to IDLE): a foreign store touches a byte of the granule.
- `FLUSH_DROP` (any state to IDLE): the trap-flush input is high.

Reset places the machine in `RS_IDLE`.

Top module: `resv_monitor`

## Requirements
- R1: The kind encoding is 0 none, 1 load-reserved, 2 store-conditional, 3 AMO. The size encoding is log2 of the byte count. A store-conditional succeeds only when all of these hold: a reservation is held, the access is aligned, its address lies in the reserved granule, no breaking store arrives in the same cycle, and flush is low.
- R2: A store-conditional that fails raises no write issue and no store flag. The result code is 0 on success and 1 on failure, and it is reported with `sc_done_o`.
- R3: A foreign store whose byte range overlaps any byte of the reserved granule clears the reservation. If it arrives in the same cycle as a store-conditional, that store-conditional fails. If it arrives in the same cycle as a load-reserved, the new reservation stands.
- R4: An acquire flag is raised for a load-reserved or AMO with aq set. A release flag is raised for a store-conditional or AMO with rl set. Both flags are raised when both bits are set.
- R5: An aligned AMO is reported as both a load and a store and issues a write. It leaves the reservation unchanged.
- R6: An operation whose address is not a multiple of its size raises `misalign_o`. It raises no write, no load or store flag and no annotation, makes no store-conditional report, and leaves the reservation unchanged.
- R7: `dep_valid_o` is high only for a successful store-conditional.
- R8: Every aligned store-conditional clears the reservation, whether it succeeds or fails. A load-reserved replaces any earlier reservation.
- R9: Reset and `flush_i` clear the reservation.
- R10: All outputs are registered one cycle after the event. A cycle with kind 0 yields all-zero event outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Trap flush, drops the reservation |
| op_kind_i | input | 2 | Event kind: 0 none, 1 LR, 2 SC, 3 AMO |
| op_addr_i | input | AW | Byte address of the event |
| op_size_i | input | 2 | log2 of access bytes |
| op_aq_i | input | 1 | Acquire bit |
| op_rl_i | input | 1 | Release bit |
| snoop_valid_i | input | 1 | Foreign store present |
| snoop_addr_i | input | AW | Foreign store byte address |
| snoop_size_i | input | 2 | log2 of foreign store bytes |
| wr_issue_o | output | 1 | Store path should write memory |
| sc_done_o | output | 1 | A store-conditional result is reported |
| sc_code_o | output | 1 | Destination value: 0 success, 1 failure |
| dep_valid_o | output | 1 | Destination register is a dependency source |
| acq_o | output | 1 | Acquire-RCsc annotation |
| rel_o | output | 1 | Release-RCsc annotation |
| is_load_o | output | 1 | Operation acts as a load |
| is_store_o | output | 1 | Operation acts as a store |
| misalign_o | output | 1 | Misaligned atomic exception |
| resv_valid_o | output | 1 | A reservation is currently held |

## Verification
Two functions can fall in the same cycle: a foreign store breaking the reservation, and the hart's own store-conditional or load-reserved that consumes or replaces it. The bench aims snoops at the reserved granule in the exact cycle of a store-conditional, and also in the cycle of a new load-reserved. It does this both in directed cases and heavily in the random phase, where addresses come from a narrow window. It judges each cycle against a behavioural model. The collision must fail the store-conditional with no write, while a load-reserved issued in the same cycle must keep its fresh reservation.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LR   = 2'd1,
        OP_SC   = 2'd2,
        OP_AMO  = 2'd3
    } op_kind_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HELD = 1'b1
    } resv_state_e;

    function automatic logic [2:0] size_mask(input logic [1:0] sz);
        logic [2:0] m;
        unique case (sz)
            2'd0:    m = 3'b000;
            2'd1:    m = 3'b001;
            2'd2:    m = 3'b011;
            default: m = 3'b111;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/resv_align_chk.sv
module resv_align_chk #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    size_i,
    output logic          mis_o
);
    logic [2:0] mask;
    always_comb begin
        mask  = resv_pkg::size_mask(size_i);
        mis_o = |(addr_i[2:0] & mask);
    end
endmodule

// File: rtl/resv_snoop_hit.sv
module resv_snoop_hit #(
    parameter int AW = 16,
    parameter int GW = 3
) (
    input  logic          valid_i,
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    size_i,
    input  logic          held_i,
    input  logic [AW-GW-1:0] blk_i,
    output logic          hit_o
);
    localparam int BW = AW - GW;
    logic [AW-1:0] last_addr;
    logic [BW-1:0] lo_blk, hi_blk;
    always_comb begin
        last_addr = addr_i + AW'(resv_pkg::size_mask(size_i));
        lo_blk    = addr_i[AW-1:GW];
        hi_blk    = last_addr[AW-1:GW];
        hit_o     = valid_i && held_i && (blk_i >= lo_blk) && (blk_i <= hi_blk);
    end
endmodule

// File: rtl/resv_annot.sv
module resv_annot (
    input  resv_pkg::op_kind_e kind_i,
    input  logic               aq_i,
    input  logic               rl_i,
    input  logic               mis_i,
    output logic               acq_o,
    output logic               rel_o
);
    import resv_pkg::*;
    always_comb begin
        acq_o = !mis_i && aq_i && (kind_i == OP_LR || kind_i == OP_AMO);
        rel_o = !mis_i && rl_i && (kind_i == OP_SC || kind_i == OP_AMO);
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int AW         = 16,
    parameter int GRAN_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [1:0]    op_kind_i,
    input  logic [AW-1:0] op_addr_i,
    input  logic [1:0]    op_size_i,
    input  logic          op_aq_i,
    input  logic          op_rl_i,
    input  logic          snoop_valid_i,
    input  logic [AW-1:0] snoop_addr_i,
    input  logic [1:0]    snoop_size_i,
    output logic          wr_issue_o,
    output logic          sc_done_o,
    output logic          sc_code_o,
    output logic          dep_valid_o,
    output logic          acq_o,
    output logic          rel_o,
    output logic          is_load_o,
    output logic          is_store_o,
    output logic          misalign_o,
    output logic          resv_valid_o
);
    import resv_pkg::*;

    localparam int GW = $clog2(GRAN_BYTES);
    localparam int BW = AW - GW;

    op_kind_e    kind;
    resv_state_e state_q, state_d;
    logic [BW-1:0] blk_q, blk_d;
    logic mis, hit, acq_n, rel_n, sc_ok, in_blk;

    assign kind = op_kind_e'(op_kind_i);

    resv_align_chk #(.AW(AW)) u_align (
        .addr_i (op_addr_i),
        .size_i (op_size_i),
        .mis_o  (mis)
    );

    resv_snoop_hit #(.AW(AW), .GW(GW)) u_snoop (
        .valid_i (snoop_valid_i),
        .addr_i  (snoop_addr_i),
        .size_i  (snoop_size_i),
        .held_i  (state_q == RS_HELD),
        .blk_i   (blk_q),
        .hit_o   (hit)
    );

    resv_annot u_annot (
        .kind_i (kind),
        .aq_i   (op_aq_i),
        .rl_i   (op_rl_i),
        .mis_i  (mis),
        .acq_o  (acq_n),
        .rel_o  (rel_n)
    );

    assign in_blk = (op_addr_i[AW-1:GW] == blk_q);
    assign sc_ok  = (kind == OP_SC) && !mis && (state_q == RS_HELD) &&
                    in_blk && !hit && !flush_i;

    // Next-state logic: transitions LR_TAKE, LR_REPLACE, SC_CLOSE,
    // SNOOP_BREAK, FLUSH_DROP
    always_comb begin
        state_d = state_q;
        blk_d   = blk_q;
        if (flush_i) begin
            state_d = RS_IDLE;                       // FLUSH_DROP
        end else begin
            unique case (state_q)
                RS_IDLE: begin
                    if (kind == OP_LR && !mis) begin
                        state_d = RS_HELD;           // LR_TAKE
                        blk_d   = op_addr_i[AW-1:GW];
                    end
                end
                RS_HELD: begin
                    if (kind == OP_LR && !mis) begin
                        blk_d   = op_addr_i[AW-1:GW]; // LR_REPLACE
                    end else if (kind == OP_SC && !mis) begin
                        state_d = RS_IDLE;           // SC_CLOSE
                    end else if (hit) begin
                        state_d = RS_IDLE;           // SNOOP_BREAK
                    end
                end
                default: state_d = RS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            blk_q   <= blk_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_issue_o  <= 1'b0;
            sc_done_o   <= 1'b0;
            sc_code_o   <= 1'b0;
            dep_valid_o <= 1'b0;
            acq_o       <= 1'b0;
            rel_o       <= 1'b0;
            is_load_o   <= 1'b0;
            is_store_o  <= 1'b0;
            misalign_o  <= 1'b0;
        end else begin
            misalign_o  <= (kind != OP_NONE) && mis;
            acq_o       <= acq_n;
            rel_o       <= rel_n;
            sc_done_o   <= (kind == OP_SC) && !mis;
            sc_code_o   <= (kind == OP_SC) && !mis && !sc_ok;
            dep_valid_o <= sc_ok;
            is_load_o   <= !mis && (kind == OP_LR || kind == OP_AMO);
            is_store_o  <= sc_ok || (kind == OP_AMO && !mis);
            wr_issue_o  <= sc_ok || (kind == OP_AMO && !mis);
        end
    end

    assign resv_valid_o = (state_q == RS_HELD);
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flush_i,
    input logic [1:0] op_kind_i,
    input logic       wr_issue_o,
    input logic       sc_done_o,
    input logic       sc_code_o,
    input logic       dep_valid_o,
    input logic       acq_o,
    input logic       rel_o,
    input logic       is_load_o,
    input logic       is_store_o,
    input logic       misalign_o,
    input logic       resv_valid_o
);
    a_r2_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done_o && sc_code_o) |-> (!wr_issue_o && !is_store_o));

    a_r6_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (!wr_issue_o && !is_load_o && !is_store_o && !sc_done_o && !acq_o && !rel_o));

    a_r7_dep_on_success: assert property (@(posedge clk) disable iff (!rst_n)
        dep_valid_o |-> (sc_done_o && !sc_code_o && wr_issue_o));

    a_r8_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done_o |-> !resv_valid_o);

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !resv_valid_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind_i == 2'd0) |=> (!sc_done_o && !wr_issue_o && !misalign_o && !is_load_o && !acq_o && !rel_o));

    a_r4_acq_kind: assert property (@(posedge clk) disable iff (!rst_n)
        acq_o |-> is_load_o);
endmodule

bind resv_monitor resv_monitor_chk u_chk (.*);

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 1'b0;
    logic [1:0] op_kind_i = '0;
    logic [AW-1:0] op_addr_i = '0;
    logic [1:0] op_size_i = '0;
    logic op_aq_i = 1'b0, op_rl_i = 1'b0;
    logic snoop_valid_i = 1'b0;
    logic [AW-1:0] snoop_addr_i = '0;
    logic [1:0] snoop_size_i = '0;
    logic wr_issue_o, sc_done_o, sc_code_o, dep_valid_o, acq_o, rel_o;
    logic is_load_o, is_store_o, misalign_o, resv_valid_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural model state
    bit m_held = 0;
    int m_blk = 0;

    always #2.5 clk = ~clk;

    resv_monitor #(.AW(AW), .GRAN_BYTES(8)) u0 (.*);

    function automatic logic [9:0] outs();
        return {wr_issue_o, sc_done_o, sc_code_o, dep_valid_o, acq_o, rel_o,
                is_load_o, is_store_o, misalign_o, resv_valid_o};
    endfunction

    task automatic step(input string tag, input int k, input int a, input int s,
                        input bit aq, input bit rl, input bit sv, input int sa,
                        input int ss, input bit fl);
        bit mis, hit, ok;
        logic [9:0] exp;
        int lo, hi;
        op_kind_i = 2'(k); op_addr_i = AW'(a); op_size_i = 2'(s);
        op_aq_i = aq; op_rl_i = rl; snoop_valid_i = sv;
        snoop_addr_i = AW'(sa); snoop_size_i = 2'(ss); flush_i = fl;
        mis = (k != 0) && ((a % (1 << s)) != 0);
        lo = sa / 8;
        hi = (sa + (1 << ss) - 1) / 8;
        hit = sv && m_held && (m_blk >= lo) && (m_blk <= hi);
        ok = (k == 2) && !mis && m_held && !hit && !fl && ((a / 8) == m_blk);
        exp[9] = ok || (k == 3 && !mis);
        exp[8] = (k == 2) && !mis;
        exp[7] = (k == 2) && !mis && !ok;
        exp[6] = ok;
        exp[5] = !mis && aq && (k == 1 || k == 3);
        exp[4] = !mis && rl && (k == 2 || k == 3);
        exp[3] = !mis && (k == 1 || k == 3);
        exp[2] = ok || (k == 3 && !mis);
        exp[1] = mis;
        if (fl) m_held = 0;
        else if (k == 1 && !mis) begin m_held = 1; m_blk = a / 8; end
        else if (k == 2 && !mis) m_held = 0;
        else if (hit) m_held = 0;
        exp[0] = m_held;
        @(posedge clk);
        #1;
        checks++;
        if (outs() !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b (wr,done,code,dep,acq,rel,ld,st,mis,held)",
                     tag, outs(), exp);
        end
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R10 act=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (outs() !== 10'b0) begin
            fails++;
            $display("FAIL R9 reset act=%b exp=%b", outs(), 10'b0);
        end
        rst_n = 1'b1;
        // R1 basic pair
        step("R1 lr",     1, 16, 2, 0, 0, 0, 0, 0, 0);
        step("R1 sc ok",  2, 20, 2, 0, 0, 0, 0, 0, 0);
        // R2 SC with no reservation
        step("R2 sc none", 2, 20, 2, 0, 0, 0, 0, 0, 0);
        // R3 snoop break between
        step("R3 lr",     1, 32, 3, 0, 0, 0, 0, 0, 0);
        step("R3 snoop",  0, 0, 0, 0, 0, 1, 39, 0, 0);
        step("R3 sc",     2, 32, 3, 0, 0, 0, 0, 0, 0);
        // R3 straddling snoop and same-cycle snoop with SC
        step("R3 lr2",    1, 48, 2, 0, 0, 0, 0, 0, 0);
        step("R3 straddle miss", 0, 0, 0, 0, 0, 1, 44, 1, 0);
        step("R3 straddle hit",  0, 0, 0, 0, 0, 1, 46, 2, 0);
        step("R3 lr3",    1, 48, 2, 0, 0, 0, 0, 0, 0);
        step("R3 sc+snoop", 2, 48, 2, 0, 0, 1, 48, 0, 0);
        step("R3 lr+snoop", 1, 64, 2, 0, 0, 1, 64, 3, 0);
        step("R3 sc after", 2, 64, 2, 0, 0, 0, 0, 0, 0);
        // R4 annotations
        step("R4 lr aqrl", 1, 80, 2, 1, 1, 0, 0, 0, 0);
        step("R4 sc aqrl", 2, 80, 2, 1, 1, 0, 0, 0, 0);
        // R5 AMO
        step("R5 lr",     1, 96, 2, 0, 0, 0, 0, 0, 0);
        step("R5 amo",    3, 200, 3, 1, 1, 0, 0, 0, 0);
        step("R5 sc",     2, 96, 2, 0, 0, 0, 0, 0, 0);
        // R6 misaligned
        step("R6 lr",     1, 112, 2, 0, 0, 0, 0, 0, 0);
        step("R6 mis lr", 1, 130, 2, 1, 0, 0, 0, 0, 0);
        step("R6 mis sc", 2, 114, 3, 0, 1, 0, 0, 0, 0);
        step("R6 mis amo",3, 113, 1, 1, 1, 0, 0, 0, 0);
        step("R6 sc ok",  2, 112, 2, 0, 0, 0, 0, 0, 0);
        // R8 LR replace, SC to old granule fails, SC clears
        step("R8 lr a",   1, 128, 2, 0, 0, 0, 0, 0, 0);
        step("R8 lr b",   1, 144, 2, 0, 0, 0, 0, 0, 0);
        step("R8 sc old", 2, 128, 2, 0, 0, 0, 0, 0, 0);
        step("R8 sc again", 2, 144, 2, 0, 0, 0, 0, 0, 0);
        // R7 dependency only on success
        step("R7 lr",     1, 160, 3, 0, 0, 0, 0, 0, 0);
        step("R7 sc",     2, 160, 3, 0, 0, 0, 0, 0, 0);
        // R9 flush
        step("R9 lr",     1, 176, 2, 0, 0, 0, 0, 0, 0);
        step("R9 flush",  0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R9 sc",     2, 176, 2, 0, 0, 0, 0, 0, 0);
        step("R9 lr2",    1, 176, 2, 0, 0, 0, 0, 0, 0);
        step("R9 sc+flush", 2, 176, 2, 0, 0, 0, 0, 0, 1);
        idle("R10 idle");
        // random phase over a narrow window
        for (int i = 0; i < 4000; i++) begin
            step("R1..R10 random",
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 63)),
                 int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 2) == 0), int'($urandom_range(0, 63)),
                 int'($urandom_range(0, 3)), ($urandom_range(0, 30) == 0));
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule